// File: doc/BRIEF.md
# Radix-8 Digit-Recurrence Divider Core

This block divides one normalized mantissa by another with a radix-8 digit recurrence. It produces three quotient bits per clock. The partial residual is kept as a redundant pair of words, a sum word and a carry word. Each radix-8 digit is carried as two small parts: a high part weighted by four and a low part weighted by one, each in the range -2 to 2. With digits built this way, the divisor multiples are only shifts and inversions. A quotient-digit selector looks at a short assimilated estimate of the next residual and at the three divisor bits that follow the leading one. Selection is retimed: it runs at the end of the cycle that produces a residual, and the chosen digit parts are registered for the following cycle.

Both operands are mantissas of `MANT_W` bits with the top bit set. The divisor is treated as a fraction in [1/2, 1). The dividend is treated the same way, except that when it is not below the divisor it is moved one place further right, so the starting residual is always smaller than the divisor. There is no separate load cycle. The first of the `ITERS` iterations runs with the digit registers preset to high 0 and low -1 on a zero residual, and that brings the dividend into the residual. The remaining `ITERS-1` iterations each emit one digit pair, most significant first. A downstream converter assembles these digits into the quotient and rounds it.

The controller has four states. IDLE waits for `start` and goes to LOAD when it comes. LOAD runs the preset iteration and always goes to ITER. ITER emits one digit per cycle and goes to FINISH after the last digit. FINISH raises `done` for one cycle, goes back to LOAD if `start` is high in that cycle, and otherwise goes to IDLE. `res_neg` is the sign of the full carry-propagate sum of the residual words.

Top module: `srt8_div`

## Requirements
- R1: After reset, `busy`, `done` and `digit_valid` are low and `res_neg` is low.
- R2: A `start` sampled high in IDLE or FINISH makes `busy` high from the next cycle for exactly `ITERS` (20) cycles. `done` then stays high for exactly one cycle, with `busy` low.
- R3: Each operation emits exactly `ITERS-1` (19) digit pairs on consecutive cycles, starting in the second busy cycle. `digit_hi` and `digit_lo` are 3-bit two's complement values in {-2..2}. Digit j has the value 4*`digit_hi` + `digit_lo`.
- R4: Let Xs = dividend when dividend >= divisor, and Xs = 2*dividend otherwise. Let Dd = 2*divisor, and let Q be the 19 digits read as a signed radix-8 integer. Then floor(Xs*8^19 / Dd) equals Q when the remainder Xs*8^19 - Q*Dd is non-negative, and equals Q-1 when it is negative.
- R5: The remainder Xs*8^19 - Q*Dd has magnitude at most Dd.
- R6: In the `done` cycle, `res_neg` is 1 exactly when that remainder is negative. It is 0 when the remainder is zero.
- R7: The pre-shift decision follows R4 at the boundaries: equal operands, dividend one below divisor, divisor of exactly one half (only the top bit set), and divisor of all ones.
- R8: A `start` pulse, or any change of `dividend` and `divisor`, during a busy cycle has no effect on the running operation's digits, `res_neg` or timing.
- R9: A `start` in the `done` cycle begins a new operation at once. `res_neg` in that cycle still belongs to the finished operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division (accepted in IDLE or FINISH) |
| dividend | input | MANT_W | Normalized dividend mantissa, top bit set |
| divisor | input | MANT_W | Normalized divisor mantissa, top bit set |
| busy | output | 1 | High during the preset iteration and the digit iterations |
| done | output | 1 | One-cycle pulse after the last digit |
| digit_valid | output | 1 | A digit pair is present this cycle |
| digit_hi | output | 3 | High digit part, weight 4, two's complement |
| digit_lo | output | 3 | Low digit part, weight 1, two's complement |
| res_neg | output | 1 | Sign of the final residual, valid with `done` |

## Verification
Two events can fall in the same cycle: the FINISH cycle, which reports the finished division's `done` and `res_neg`, and the acceptance of the next `start`, which clears the residual words on the following edge. The bench issues operations back to back, so each new `start` is driven in the cycle where `done` is high. The scoreboard judges the sign sampled in that cycle against the finished operation's remainder. It also checks that the next digit stream begins exactly two cycles later, with no digits missing or extra.

// File: rtl/srt8_pkg.sv
package srt8_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ITER,
        ST_FINISH
    } ctrl_state_e;

    typedef logic signed [2:0] digit_t;

    localparam int LEVEL_MIN = -6;
    localparam int LEVEL_MAX = 7;

    // Threshold for choosing digit level k, in 1/16 units of 8*w.
    // dsc is floor(16*d), from 8 to 15. The value is the lowest bound that
    // keeps the next residual within [-d, d] for every d in the interval.
    function automatic int level_thr(int k, int dsc);
        if (k >= 1)
            return (k - 1) * (dsc + 1);
        else
            return (k - 1) * dsc;
    endfunction

    // High part of a digit in -7..7: round(q/4) with ties upward.
    function automatic digit_t hi_part(int lvl);
        return digit_t'((lvl + 2) >>> 2);
    endfunction

    function automatic digit_t lo_part(int lvl);
        return digit_t'(lvl - 4 * ((lvl + 2) >>> 2));
    endfunction

endpackage

// File: rtl/srt8_ctrl.sv
module srt8_ctrl
    import srt8_pkg::*;
#(
    parameter int DIGITS = 19
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic load_cyc,
    output logic iter_cyc,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(DIGITS + 1);

    ctrl_state_e state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             last_digit;

    assign last_digit = (cnt == CNT_W'(DIGITS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_LOAD)
                cnt <= '0;
            else if (state == ST_ITER)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_LOAD;
            ST_LOAD:   state_nx = ST_ITER;
            ST_ITER:   if (last_digit) state_nx = ST_FINISH;
            ST_FINISH: state_nx = start ? ST_LOAD : ST_IDLE;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        load_cyc = 1'b0;
        iter_cyc = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:   accept = start;
            ST_LOAD:   begin load_cyc = 1'b1; busy = 1'b1; end
            ST_ITER:   begin iter_cyc = 1'b1; busy = 1'b1; end
            ST_FINISH: begin done = 1'b1; accept = start; end
        endcase
    end

    // Independent tally of digit cycles since the preset iteration.
    logic [CNT_W-1:0] seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seen <= '0;
        else if (load_cyc)
            seen <= '0;
        else if (iter_cyc)
            seen <= seen + 1'b1;
    end

    // R2
    start_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && load_cyc));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R3
    digit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (seen == CNT_W'(DIGITS)));

endmodule

// File: rtl/srt8_mult.sv
module srt8_mult
    import srt8_pkg::*;
#(
    parameter int W  = 56,
    parameter int SH = 0
) (
    input  digit_t         q,
    input  logic [W-1:0]   m,
    output logic [W-1:0]   term,
    output logic           cin
);
    logic [W-1:0] mag;

    always_comb begin
        if (int'(q) == 1 || int'(q) == -1)
            mag = m << SH;
        else if (int'(q) == 2 || int'(q) == -2)
            mag = m << (SH + 1);
        else
            mag = '0;

        if (int'(q) > 0) begin
            term = ~mag;
            cin  = 1'b1;
        end else begin
            term = mag;
            cin  = 1'b0;
        end
    end

endmodule

// File: rtl/srt8_csa.sv
module srt8_csa #(
    parameter int W = 56
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic [W-1:0] cy
);
    logic [W-1:0] maj;

    assign s   = a ^ b ^ c;
    assign maj = (a & b) | (a & c) | (b & c);
    assign cy  = {maj[W-2:0], cin};

endmodule

// File: rtl/srt8_sel.sv
module srt8_sel
    import srt8_pkg::*;
#(
    parameter int EST_W  = 9,
    parameter int DSEL_W = 3
) (
    input  logic signed [EST_W-1:0] est,
    input  logic [DSEL_W-1:0]       dfrac,
    output digit_t                  q_hi,
    output digit_t                  q_lo
);
    localparam int NLEV  = LEVEL_MAX - LEVEL_MIN + 1;
    localparam int DBASE = 1 << DSEL_W;

    logic [NLEV-1:0] ge;
    int              lvl;

    for (genvar g = 0; g < NLEV; g++) begin : g_cmp
        assign ge[g] = int'(est) >= level_thr(LEVEL_MIN + g, DBASE + int'(dfrac));
    end

    always_comb begin
        lvl  = $countones(ge) + LEVEL_MIN - 1;
        q_hi = hi_part(lvl);
        q_lo = lo_part(lvl);
    end

endmodule

// File: rtl/srt8_div.sv
module srt8_div
    import srt8_pkg::*;
#(
    parameter int MANT_W = 53,
    parameter int ITERS  = 20,
    parameter int INT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MANT_W-1:0] dividend,
    input  logic [MANT_W-1:0] divisor,
    output logic              busy,
    output logic              done,
    output logic              digit_valid,
    output logic [2:0]        digit_hi,
    output logic [2:0]        digit_lo,
    output logic              res_neg
);
    localparam int FRAC_W = MANT_W + 1;
    localparam int RES_W  = FRAC_W + INT_W;
    localparam int DIGITS = ITERS - 1;
    localparam int EST_W  = INT_W + 7;
    localparam int DSEL_W = 3;

    logic accept, load_cyc, iter_cyc;

    srt8_ctrl #(.DIGITS(DIGITS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .accept   (accept),
        .load_cyc (load_cyc),
        .iter_cyc (iter_cyc),
        .busy     (busy),
        .done     (done)
    );

    logic [FRAC_W-1:0] xr, dr, xpre;
    logic [RES_W-1:0]  ws, wc;
    digit_t            qh, ql;

    // Pre-shift: keep the first residual below the divisor.
    assign xpre = (dividend >= divisor) ? {1'b0, dividend} : {dividend, 1'b0};

    logic [RES_W-1:0] mult_src, ws_sh, wc_sh;
    assign mult_src = {{INT_W{1'b0}}, (load_cyc ? xr : dr)};
    assign ws_sh    = ws << 3;
    assign wc_sh    = wc << 3;

    logic [RES_W-1:0] term_h, term_l, s1, c1, ws_n, wc_n;
    logic             cin_h, cin_l;

    srt8_mult #(.W(RES_W), .SH(2)) u_mult_hi (
        .q (qh), .m (mult_src), .term (term_h), .cin (cin_h)
    );

    srt8_mult #(.W(RES_W), .SH(0)) u_mult_lo (
        .q (ql), .m (mult_src), .term (term_l), .cin (cin_l)
    );

    srt8_csa #(.W(RES_W)) u_csa_hi (
        .a (ws_sh), .b (wc_sh), .c (term_h), .cin (cin_h), .s (s1), .cy (c1)
    );

    srt8_csa #(.W(RES_W)) u_csa_lo (
        .a (s1), .b (c1), .c (term_l), .cin (cin_l), .s (ws_n), .cy (wc_n)
    );

    // Retimed selection on the residual being produced this cycle.
    logic signed [EST_W-1:0] est;
    logic [DSEL_W-1:0]       dfrac;
    digit_t                  qh_n, ql_n;

    assign est   = $signed(ws_n[RES_W-1 -: EST_W] + wc_n[RES_W-1 -: EST_W]);
    assign dfrac = dr[FRAC_W-2 -: DSEL_W];

    srt8_sel #(.EST_W(EST_W), .DSEL_W(DSEL_W)) u_sel (
        .est   (est),
        .dfrac (dfrac),
        .q_hi  (qh_n),
        .q_lo  (ql_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xr <= '0;
            dr <= '0;
            ws <= '0;
            wc <= '0;
            qh <= digit_t'(0);
            ql <= digit_t'(0);
        end else if (accept) begin
            xr <= xpre;
            dr <= {divisor, 1'b0};
            ws <= '0;
            wc <= '0;
            qh <= digit_t'(0);
            ql <= digit_t'(-1);
        end else if (load_cyc || iter_cyc) begin
            ws <= ws_n;
            wc <= wc_n;
            qh <= qh_n;
            ql <= ql_n;
        end
    end

    assign digit_valid = iter_cyc;
    assign digit_hi    = qh;
    assign digit_lo    = ql;
    assign res_neg     = ($signed(ws + wc) < 0);

    // R3
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        digit_valid |-> (int'(qh) >= -2 && int'(qh) <= 2 &&
                         int'(ql) >= -2 && int'(ql) <= 2));

    // R5
    est_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_cyc || iter_cyc) |->
            (int'(est) <  8 * (9 + int'(dfrac)) &&
             int'(est) > -8 * (9 + int'(dfrac)) - 2));

    // R8
    operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iter_cyc |-> ($stable(dr) && $stable(xr)));

endmodule

// File: tb/srt8_div_bench.sv
module srt8_div_bench;
    localparam int MW     = 53;
    localparam int ITERS  = 20;
    localparam int DIGITS = ITERS - 1;
    localparam int SH     = 3 * DIGITS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [MW-1:0] dividend = '0;
    logic [MW-1:0] divisor = '0;
    logic          busy, done, digit_valid, res_neg;
    logic [2:0]    digit_hi, digit_lo;

    always #10 clk = ~clk;

    srt8_div #(.MANT_W(MW), .ITERS(ITERS)) u_srt8_div (
        .clk (clk), .rst_n (rst_n), .start (start),
        .dividend (dividend), .divisor (divisor),
        .busy (busy), .done (done), .digit_valid (digit_valid),
        .digit_hi (digit_hi), .digit_lo (digit_lo), .res_neg (res_neg)
    );

    typedef struct {
        logic [127:0] xs;
        logic [127:0] dd;
        logic [127:0] qf;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic signed [127:0] act, input logic signed [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Driver: push expected item, pulse start.
    task automatic run_op(input logic [MW-1:0] x, input logic [MW-1:0] d);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        e.xs = (x >= d) ? 128'(x) : (128'(x) << 1);
        e.dd = 128'(d) << 1;
        e.qf = (e.xs << SH) / e.dd;
        exp_q.push_back(e);
        start    = 1'b1;
        dividend = x;
        divisor  = d;
        @(negedge clk);
        start = 1'b0;
    endtask

    function automatic logic [MW-1:0] rnd_mant();
        logic [63:0] r;
        r = {$urandom(), $urandom()};
        return {1'b1, r[MW-2:0]};
    endfunction

    // Monitor / scoreboard
    initial begin
        logic signed [127:0] qv;
        int nd;
        int nb;
        qv = '0; nd = 0; nb = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (busy) nb++;
                if (digit_valid) begin
                    qv = qv * 8 + 128'(4 * int'($signed(digit_hi)) + int'($signed(digit_lo)));
                    nd++;
                end
                if (done) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R2", "done without request", 1, 0);
                    end else begin
                        exp_t e;
                        logic signed [127:0] rem;
                        logic signed [127:0] fl;
                        bit neg;
                        e   = exp_q.pop_front();
                        rem = $signed(e.xs << SH) - qv * $signed(e.dd);
                        neg = (rem < 0);
                        fl  = qv - (neg ? 128'sd1 : 128'sd0);
                        // R2 busy length
                        check(nb == ITERS, "R2", "busy cycles", nb, ITERS);
                        // R3 digit count
                        check(nd == DIGITS, "R3", "digit count", nd, DIGITS);
                        // R4 and R7 quotient vs integer division
                        check(fl == $signed(e.qf), "R4", "floor quotient", fl, $signed(e.qf));
                        // R5 remainder bound
                        check((neg ? -rem : rem) <= $signed(e.dd), "R5", "remainder magnitude",
                              neg ? -rem : rem, $signed(e.dd));
                        // R6 and R9 sign in the done cycle
                        check(res_neg == neg, "R6", "residual sign", 128'(res_neg), 128'(neg));
                    end
                    qv = '0; nd = 0; nb = 0;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            summary();
        end
    end

    localparam logic [MW-1:0] DMIN = {1'b1, {(MW-1){1'b0}}};
    localparam logic [MW-1:0] DMAX = {MW{1'b1}};

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !digit_valid && !res_neg, "R1", "idle outputs after reset",
              128'({busy, done, digit_valid, res_neg}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !digit_valid, "R1", "idle after release",
              128'({busy, done, digit_valid}), 0);

        // R7 boundary operands
        run_op(DMIN, DMIN);
        run_op(DMAX, DMAX);
        run_op(DMAX - 1'b1, DMAX);
        run_op(DMAX, DMIN);
        run_op(DMIN, DMAX);
        run_op(DMIN + 1'b1, DMIN);
        run_op(DMIN, DMIN + 1'b1);
        run_op(rnd_mant(), DMIN);
        run_op(rnd_mant(), DMAX);

        // R8 stray start and operand change during busy
        run_op(rnd_mant(), rnd_mant());
        repeat (5) @(negedge clk);
        start = 1'b1; dividend = DMAX; divisor = DMIN;
        @(negedge clk);
        start = 1'b0; dividend = rnd_mant(); divisor = rnd_mant();
        run_op(DMAX, DMAX - 1'b1);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;

        // Random operands, mostly back to back (R9), some with idle gaps
        for (int i = 0; i < 40; i++) begin
            run_op(rnd_mant(), rnd_mant());
            if (i % 7 == 3) repeat (25) @(negedge clk);
        end

        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        // R2 returns to idle
        check(!busy && !done, "R2", "idle after last operation", 128'({busy, done}), 0);
        summary();
    end

endmodule